// File: doc/BRIEF.md
# Two-wire serial memory slave with read engine

This block is the bus-facing half of a 16K x 8 serial memory that sits on a two-wire (I2C-style) bus. It samples the bus clock and data lines with a fast system clock and finds start and stop conditions. It checks the device select byte against two strap inputs and acknowledges the bytes meant for it. On a write it loads a 14-bit word address. It answers current-address, random and sequential reads from an internal array model. The block never drives the data line high. It only asserts a pull-low enable, which the pad turns into an open-drain driver.

Data bytes of a write transaction are not stored here. Each one is handed on as a one-cycle valid pulse, with its address, to a separate page-write block. One address counter serves both reads and writes and keeps its value between transactions. Reads advance it across the whole array. Writes advance it only within the current 64-byte page.

The array model is computed from the address instead of being stored, so every read has a known expected value.

Top module: `twsSlave`

## Requirements
- R1: A falling data line while the clock is high (start) puts the block into select-byte reception with the data line released, whatever it was doing. A rising data line while the clock is high (stop) returns it to idle with the data line released.
- R2: The select byte is sent MSB first. Bits 7:4 must be 1010, bit 3 is ignored, bits 2:1 must equal `strapAddr`, and bit 0 selects read (1) or write (0). On a match the block pulls the data line low for the ninth clock. On a mismatch it never pulls the line low, emits no write bytes and leaves the address counter unchanged until the next start.
- R3: After a write select, the block acknowledges two address bytes. Bits 7:6 of the first byte are ignored. The address counter becomes {first[5:0], second[7:0]}.
- R4: Each further byte of a write is acknowledged. It appears as a one-cycle `wrValid` pulse, with `wrAddr` equal to the counter and `wrData` equal to the byte. The counter's low 6 bits then increment and wrap inside the 64-byte page, and bits 13:6 stay unchanged.
- R5: A read select with no address phase returns the byte at the counter. The counter holds the address after the last byte read or written, and it keeps that value across stop and start.
- R6: A write select with two address bytes, then a repeated start and a read select, returns data starting at the loaded address.
- R7: Each master acknowledge (data low in the ninth clock) in a read advances the counter by one and sends the next byte. Address 0x3FFF is followed by 0x0000.
- R8: A master non-acknowledge ends the read. The block releases the data line and drives nothing until the next start, so further clocks read back 0xFF.
- R9: The array model returns, for address a, the byte a[7:0] XOR a[13:8] (zero-extended) XOR 0x80.
- R10: The pull-low enable changes only after a synchronized clock fall, a start or a stop. It never changes while the bus clock is high. Read data is sent MSB first.
- R11: After reset the data line is released, `wrValid` is low and the address counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| strapAddr | input | 2 | Strap value that select bits 2:1 must match |
| sdaPullLow | output | 1 | Open-drain enable: 1 pulls the data line low |
| wrValid | output | 1 | One-cycle strobe for a received write data byte |
| wrAddr | output | 14 | Word address of the write byte |
| wrData | output | 8 | Write data byte |

## Verification
A wrong bit count or a lost start shows at the pins within one byte. The acknowledge then falls in the wrong clock, or read data comes out shifted. A corrupted address counter does not show until the next read, where the returned byte differs from the array model. That read comes one transaction later for current-address reads, or at the page and array wrap points for sequential and page traffic. A late or early drive change shows as a data-line edge while the clock is high, which the bus reads as a false start or stop. The bench therefore watches the line for edges during every high clock phase.

// File: rtl/twsPkg.sv
package twsPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_WDATA,
    ST_RDATA
  } twsState_e;

  // bus events seen by the control, produced by the datapath
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
    logic sdaBit;
  } twsEvt_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic loadHi;
    logic loadLo;
    logic wrByte;
    logic incRead;
    logic loadTx;
    logic shiftTx;
    logic drvAck;
    logic relBus;
  } twsCmd_t;

endpackage

// File: rtl/twsDatapath.sv
module twsDatapath
  import twsPkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int PAGE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  twsCmd_t           cmd,
  output twsEvt_t           evt,
  output logic [7:0]        rxByte,
  output logic              sdaPullLow,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData
);

  localparam int HI_W = ADDR_W - 8;

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclP, sdaP;
  logic [7:0]        rxShift;
  logic [6:0]        txShift;
  logic [ADDR_W-1:0] addrCnt;
  logic [7:0]        memData;

  function automatic logic [7:0] memByte(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ 8'(a >> 8) ^ 8'h80;
  endfunction

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclP    <= sclS;
      sdaP    <= sdaS;
    end
  end

  assign evt.sclRise  = sclS & ~sclP;
  assign evt.sclFall  = ~sclS & sclP;
  assign evt.startDet = sclS & sclP & sdaP & ~sdaS;
  assign evt.stopDet  = sclS & sclP & ~sdaP & sdaS;
  assign evt.sdaBit   = sdaS;

  assign rxByte  = rxShift;
  assign memData = memByte(addrCnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift    <= '0;
      txShift    <= '0;
      addrCnt    <= '0;
      sdaPullLow <= 1'b0;
      wrValid    <= 1'b0;
      wrAddr     <= '0;
      wrData     <= '0;
    end else begin
      wrValid <= 1'b0;
      if (cmd.shiftIn) rxShift <= {rxShift[6:0], sdaS};
      if (cmd.loadHi)  addrCnt[ADDR_W-1:8] <= rxShift[HI_W-1:0];
      if (cmd.loadLo)  addrCnt[7:0] <= rxShift;
      if (cmd.wrByte) begin
        wrValid <= 1'b1;
        wrAddr  <= addrCnt;
        wrData  <= rxShift;
        addrCnt <= {addrCnt[ADDR_W-1:PAGE_W], addrCnt[PAGE_W-1:0] + PAGE_W'(1)};
      end
      if (cmd.incRead) addrCnt <= addrCnt + ADDR_W'(1);
      if (cmd.relBus)  sdaPullLow <= 1'b0;
      if (cmd.drvAck)  sdaPullLow <= 1'b1;
      if (cmd.loadTx) begin
        txShift    <= memData[6:0];
        sdaPullLow <= ~memData[7];
      end
      if (cmd.shiftTx) begin
        txShift    <= {txShift[5:0], 1'b0};
        sdaPullLow <= ~txShift[6];
      end
    end
  end

endmodule

// File: rtl/twsControl.sv
module twsControl
  import twsPkg::*;
#(
  parameter logic [3:0] DEV_ID = 4'b1010
) (
  input  logic       clk,
  input  logic       rstN,
  input  twsEvt_t    evt,
  input  logic [7:0] rxByte,
  input  logic [1:0] strapAddr,
  output twsCmd_t    cmd,
  output twsState_e  state
);

  localparam logic [7:0] SEL_MASK = 8'b1111_0110;
  localparam logic [3:0] LAST_BIT = 4'd8;
  localparam logic [3:0] ACK_END  = 4'd9;

  twsState_e  nextState;
  logic [3:0] bitCnt, nextCnt;
  logic       readSel, masterAck;
  logic       selMatch, capSel;

  assign selMatch = (rxByte & SEL_MASK) == {DEV_ID, 1'b0, strapAddr, 1'b0};

  always_comb begin
    cmd       = '0;
    nextState = state;
    nextCnt   = bitCnt;
    capSel    = 1'b0;
    if (evt.startDet) begin
      nextState  = ST_SEL;
      nextCnt    = '0;
      cmd.relBus = 1'b1;
    end else if (evt.stopDet) begin
      nextState  = ST_IDLE;
      nextCnt    = '0;
      cmd.relBus = 1'b1;
    end else if (state != ST_IDLE) begin
      if (evt.sclRise && bitCnt < ACK_END) begin
        if (bitCnt < LAST_BIT && state != ST_RDATA) cmd.shiftIn = 1'b1;
        nextCnt = 4'(bitCnt + 4'd1);
      end
      if (evt.sclFall) begin
        if (bitCnt == LAST_BIT) begin
          unique case (state)
            ST_SEL: begin
              if (selMatch) begin
                cmd.drvAck = 1'b1;
                capSel     = 1'b1;
              end else begin
                cmd.relBus = 1'b1;
                nextState  = ST_IDLE;
                nextCnt    = '0;
              end
            end
            ST_ADDR_HI: begin cmd.loadHi = 1'b1; cmd.drvAck = 1'b1; end
            ST_ADDR_LO: begin cmd.loadLo = 1'b1; cmd.drvAck = 1'b1; end
            ST_WDATA:   begin cmd.wrByte = 1'b1; cmd.drvAck = 1'b1; end
            ST_RDATA:   begin cmd.incRead = 1'b1; cmd.relBus = 1'b1; end
            default: ;
          endcase
        end else if (bitCnt == ACK_END) begin
          nextCnt = '0;
          unique case (state)
            ST_SEL: begin
              if (readSel) begin
                cmd.loadTx = 1'b1;
                nextState  = ST_RDATA;
              end else begin
                cmd.relBus = 1'b1;
                nextState  = ST_ADDR_HI;
              end
            end
            ST_ADDR_HI: begin cmd.relBus = 1'b1; nextState = ST_ADDR_LO; end
            ST_ADDR_LO: begin cmd.relBus = 1'b1; nextState = ST_WDATA; end
            ST_WDATA:   cmd.relBus = 1'b1;
            ST_RDATA: begin
              if (masterAck) cmd.loadTx = 1'b1;
              else begin
                cmd.relBus = 1'b1;
                nextState  = ST_IDLE;
              end
            end
            default: ;
          endcase
        end else if (state == ST_RDATA && bitCnt != 4'd0) begin
          cmd.shiftTx = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      readSel   <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state  <= nextState;
      bitCnt <= nextCnt;
      if (capSel) readSel <= rxByte[0];
      if (evt.sclRise && bitCnt == LAST_BIT) masterAck <= ~evt.sdaBit;
    end
  end

endmodule

// File: rtl/twsSlave.sv
module twsSlave
  import twsPkg::*;
#(
  parameter int         ADDR_W      = 14,
  parameter int         PAGE_W      = 6,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_ID      = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [1:0]        strapAddr,
  output logic              sdaPullLow,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData
);

  twsCmd_t    ctlCmd;
  twsEvt_t    dpEvt;
  twsState_e  ctlState;
  logic [7:0] dpRxByte;

  twsControl #(.DEV_ID(DEV_ID)) ctl_i (
    .clk(clk), .rstN(rstN), .evt(dpEvt), .rxByte(dpRxByte),
    .strapAddr(strapAddr), .cmd(ctlCmd), .state(ctlState)
  );

  twsDatapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .cmd(ctlCmd),
    .evt(dpEvt), .rxByte(dpRxByte), .sdaPullLow(sdaPullLow),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData)
  );

endmodule

// File: rtl/twsChecker.sv
module twsChecker
  import twsPkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      sdaPullLow,
  input logic      wrValid,
  input twsState_e state,
  input twsEvt_t   evt
);

  AST_START_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    evt.startDet |=> (state == ST_SEL && !sdaPullLow)); // R1
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (evt.stopDet && !evt.startDet) |=> (state == ST_IDLE && !sdaPullLow)); // R1
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaPullLow); // R2
  AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> $past(evt.sclFall || evt.startDet || evt.stopDet)); // R10
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid); // R4
  AST_WR_IN_DATA: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (state == ST_WDATA)); // R4

endmodule

bind twsSlave twsChecker chk_i (
  .clk(clk), .rstN(rstN), .sdaPullLow(sdaPullLow), .wrValid(wrValid),
  .state(ctlState), .evt(dpEvt)
);

// File: tb/twsSlave_tb.sv
`timescale 1ns/1ps
module twsSlave_tb_top;

  localparam int Q = 8;         // system clocks per quarter bus bit
  localparam int NVEC = 8;
  // {kind, count, spare, address}; kind 0 = page write, 1 = random read, 2 = current read
  localparam logic [31:0] VEC [NVEC] = '{
    {2'd1, 6'd3, 10'd0, 14'h0123},
    {2'd2, 6'd2, 10'd0, 14'h0000},
    {2'd0, 6'd4, 10'd0, 14'h1F3E},
    {2'd2, 6'd1, 10'd0, 14'h0000},
    {2'd1, 6'd4, 10'd0, 14'h3FFE},
    {2'd2, 6'd2, 10'd0, 14'h0000},
    {2'd0, 6'd1, 10'd0, 14'h2A10},
    {2'd1, 6'd1, 10'd0, 14'h0555}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mScl = 1'b1, mSda = 1'b1;
  logic [1:0]  strap = 2'b10;
  logic        pull, wrValid;
  logic [13:0] wrAddr;
  logic [7:0]  wrData;
  wire         busSda = mSda & ~pull;

  int nChecks = 0, nFail = 0;
  int capN = 0, pullCycles = 0, glitchCnt = 0;
  logic [13:0] capA [64];
  logic [7:0]  capD [64];
  logic        pullPrev = 1'b0;
  logic [13:0] model = '0;

  always #2 clk = ~clk;

  twsSlave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(busSda), .strapAddr(strap),
    .sdaPullLow(pull), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData)
  );

  always @(posedge clk) begin
    if (wrValid && capN < 64) begin
      capA[capN] = wrAddr;
      capD[capN] = wrData;
      capN++;
    end
    if (rstN && pull) pullCycles++;
    if (rstN && mScl && pull != pullPrev) glitchCnt++;
    pullPrev = pull;
  end

  function automatic logic [7:0] memRef(input logic [13:0] a);
    return a[7:0] ^ {2'b00, a[13:8]} ^ 8'h80;   // R9
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic busStart();
    mSda = 1'b1; waitQ(); mScl = 1'b1; waitQ();
    mSda = 1'b0; waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    mSda = 1'b0; waitQ(); mScl = 1'b1; waitQ(); mSda = 1'b1; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; waitQ(); mScl = 1'b1; waitQ(); waitQ(); mScl = 1'b0; waitQ();
    end
    mSda = 1'b1; waitQ(); mScl = 1'b1; waitQ();
    acked = (busSda == 1'b0);
    waitQ(); mScl = 1'b0; waitQ();
  endtask

  task automatic recvByte(input bit nack, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(); mScl = 1'b1; waitQ(); b[i] = busSda; waitQ(); mScl = 1'b0; waitQ();
    end
    mSda = nack; waitQ(); mScl = 1'b1; waitQ(); waitQ(); mScl = 1'b0; waitQ();
    mSda = 1'b1;
  endtask

  function automatic logic [7:0] selByte(input bit rd);
    return {4'b1010, 1'b0, strap, rd};
  endfunction

  task automatic readBytes(input int n, input string req);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      recvByte(k == n - 1, b);
      chk(b == memRef(model), req, b, memRef(model));
      model = model + 14'd1;
    end
  endtask

  task automatic curRead(input int n, input string req);
    bit a;
    busStart();
    sendByte(selByte(1'b1), a);
    chk(a, {req, " select ack"}, a, 1);
    readBytes(n, req);
    busStop();
  endtask

  task automatic randRead(input logic [7:0] hi, input logic [7:0] lo, input int n, input string req);
    bit a;
    busStart();
    sendByte(selByte(1'b0), a); chk(a, "R6 write select ack", a, 1);
    sendByte(hi, a);            chk(a, "R3 high address ack", a, 1);
    sendByte(lo, a);            chk(a, "R3 low address ack", a, 1);
    busStart();
    sendByte(selByte(1'b1), a); chk(a, "R6 read select ack", a, 1);
    model = {hi[5:0], lo};
    readBytes(n, req);
    busStop();
  endtask

  task automatic pageWrite(input logic [13:0] addr, input int n);
    bit a;
    logic [13:0] exA;
    logic [7:0]  exD;
    capN = 0;
    busStart();
    sendByte(selByte(1'b0), a);      chk(a, "R3 write select ack", a, 1);
    sendByte({2'b00, addr[13:8]}, a); chk(a, "R3 high address ack", a, 1);
    sendByte(addr[7:0], a);           chk(a, "R3 low address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      sendByte(8'(8'h3C + 7 * k), a); chk(a, "R4 data ack", a, 1);
    end
    busStop();
    chk(capN == n, "R4 write byte count", capN, n);
    model = addr;
    for (int k = 0; k < n && k < capN; k++) begin
      exA = model;
      exD = 8'(8'h3C + 7 * k);
      chk(capA[k] == exA, "R4 write address", capA[k], exA);
      chk(capD[k] == exD, "R4 write data", capD[k], exD);
      model = {model[13:6], 6'(model[5:0] + 6'd1)};
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    model = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] b;
    int pc0;
    doReset();
    chk(pull == 1'b0, "R11 bus released after reset", pull, 0);
    chk(wrValid == 1'b0, "R11 no write strobe after reset", wrValid, 0);

    for (int v = 0; v < NVEC; v++) begin
      unique case (VEC[v][31:30])
        2'd0: pageWrite(VEC[v][13:0], int'(VEC[v][29:24]));
        2'd1: randRead({2'b00, VEC[v][13:8]}, VEC[v][7:0], int'(VEC[v][29:24]), "R7 random/sequential read data");
        default: curRead(int'(VEC[v][29:24]), "R5 current address read data");
      endcase
    end

    // R2: select bit 3 is ignored
    busStart();
    sendByte({4'b1010, 1'b1, strap, 1'b1}, a);
    chk(a, "R2 select with bit3 set ack", a, 1);
    readBytes(1, "R2 read data after bit3 select");
    busStop();

    // R2: mismatched strap bits get no acknowledge and change nothing
    capN = 0;
    pc0 = pullCycles;
    busStart();
    sendByte({4'b1010, 1'b0, ~strap, 1'b0}, a);
    chk(!a, "R2 mismatch no ack", a, 0);
    sendByte(8'h00, a); chk(!a, "R2 ignored byte no ack", a, 0);
    sendByte(8'h10, a); chk(!a, "R2 ignored byte no ack", a, 0);
    busStop();
    chk(pullCycles == pc0, "R2 line never pulled on mismatch", pullCycles - pc0, 0);
    chk(capN == 0, "R2 no write bytes on mismatch", capN, 0);
    curRead(1, "R2 counter unchanged after mismatch");

    // R8: a non-acknowledge ends the read
    busStart();
    sendByte(selByte(1'b1), a); chk(a, "R8 select ack", a, 1);
    readBytes(1, "R8 last byte before nack");
    recvByte(1'b1, b);
    chk(b == 8'hFF, "R8 released after nack", b, 8'hFF);
    busStop();
    curRead(1, "R8 counter advanced by one byte only");

    // R1: repeated start during the address phase aborts it
    busStart();
    sendByte(selByte(1'b0), a); chk(a, "R1 write select ack", a, 1);
    busStart();
    sendByte(selByte(1'b1), a); chk(a, "R1 read select after abort ack", a, 1);
    readBytes(1, "R1 counter kept after aborted address");
    busStop();

    // R3: top bits of the high address byte are ignored
    randRead(8'hC1, 8'h23, 2, "R3 high bits ignored read data");

    // R11: reset clears the counter
    doReset();
    curRead(1, "R11 counter zero after reset");

    chk(glitchCnt == 0, "R10 pull changed while clock high", glitchCnt, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule